// File: doc/BRIEF.md
# Region-Tagged Translation Buffer

This block is a small fully associative translation cache that sits behind eight region registers. A 64-bit virtual address is split into a 3-bit region number in its top bits and a 61-bit offset. The region number only picks one of the eight region registers. That register supplies a 24-bit address-space identifier. Each cached entry stores this identifier, a 49-bit virtual page number (offset bits 60:12, with a fixed 4 KB page) and a physical page number. Entries never store the region number. A space can therefore be reached through any region register that holds its identifier.

Four operations are supported:
- A lookup returns hit and physical page in the same cycle, plus a registered hit flag one cycle later.
- An insert writes a new entry into a victim slot.
- A ranged purge invalidates every entry whose page lies inside an aligned power-of-two byte range of one identifier.
- A purge-all empties the buffer.

Top module: `region_tlb`

## Requirements
- R1: After reset every entry is invalid, every region register holds 0 and `lkHitQ` is 0, so every lookup misses.
- R2: A region register write becomes visible on the clock edge that samples it. A lookup in the same cycle as the write uses the old value.
- R3: `lkHit` is 1 in the same cycle when a valid entry holds identifier `rr[lkVaddr[63:61]]` and page `lkVaddr[60:12]`. `lkPpn` then gives that entry's physical page. Bits 11:0 are ignored.
- R4: Entries carry no region number. Any region register holding the same identifier hits the same entry, for both lookup and purge.
- R5: `lkHitQ` equals the value `lkHit` had in the previous cycle.
- R6: An insert stores identifier `rr[insVaddr[63:61]]`, page `insVaddr[60:12]` and `insPpn`. It uses the lowest-numbered invalid slot when one exists, so no valid entry is evicted.
- R7: When all 16 slots are valid, an insert replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such full inserts.
- R8: A purge with size code s is clamped to the range 12..61. It invalidates every valid entry whose identifier equals `rr[purgeVaddr[63:61]]` and whose page bits above bit s-12 equal those of `purgeVaddr`. All other entries are kept.
- R9: A purge of size 61 or more removes every entry of that identifier, whatever the page. Entries of other identifiers remain.
- R10: `purgeAllEn` invalidates every entry on the next edge.
- R11: An insert in the same cycle as a purge or a purge-all is dropped. The purge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rrWrEn | input | 1 | Region register write strobe |
| rrWrIdx | input | 3 | Region register index |
| rrWrData | input | 24 | Identifier to write |
| lkVaddr | input | 64 | Lookup virtual address |
| lkHit | output | 1 | Combinational lookup hit |
| lkPpn | output | 40 | Physical page of the hit, 0 on miss |
| lkHitQ | output | 1 | Lookup hit registered one cycle later |
| insEn | input | 1 | Insert request |
| insVaddr | input | 64 | Virtual address of the new entry |
| insPpn | input | 40 | Physical page of the new entry |
| purgeEn | input | 1 | Ranged purge request |
| purgeVaddr | input | 64 | Purge target address |
| purgeSize | input | 6 | log2 of the purge byte range |
| purgeAllEn | input | 1 | Invalidate all entries |

## Verification
The assertions assume that requests are sampled only on clock edges and that the operation inputs are stable and known while reset is released. They do not rely on unique entries: when duplicate page entries exist, the lowest slot wins, and no check relies on any other choice. The stimulus inserts each identifier and page pair at most once between purges. It drives every input just after the falling edge. It issues overlapping insert and purge requests only in the dedicated conflict scenario, where the expected outcome is that the insert is lost.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  // strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic ins;
    logic purge;
    logic purgeAll;
  } tlbStrb_t;
endpackage

// File: rtl/rtlb_ctrl.sv
module rtlb_ctrl
  import rtlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insEn,
  input  logic               purgeEn,
  input  logic               purgeAllEn,
  input  logic [NUM_ENT-1:0] freeVec,
  output tlbStrb_t           strb,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] firstFree;
  logic             anyFree;

  always_comb begin
    firstFree = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (freeVec[i]) firstFree = IDX_W'(i);
    end
  end

  assign anyFree = |freeVec;
  assign victim  = anyFree ? firstFree : ptrQ;

  always_comb begin
    strb.purgeAll = purgeAllEn;
    strb.purge    = purgeEn;
    strb.ins      = insEn & ~purgeEn & ~purgeAllEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strb.ins && !anyFree) begin
      if (ptrQ == IDX_W'(NUM_ENT - 1)) ptrQ <= '0;
      else                             ptrQ <= ptrQ + 1'b1;
    end
  end

  // R6
  victim_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ins && (freeVec != '0)) |-> freeVec[victim]);
endmodule

// File: rtl/rtlb_dp.sv
module rtlb_dp
  import rtlb_pkg::*;
#(
  parameter int NUM_ENT  = 16,
  parameter int RID_W    = 24,
  parameter int PPN_W    = 40,
  parameter int VA_W     = 64,
  parameter int RN_W     = 3,
  parameter int PG_SHIFT = 12,
  parameter int SZ_W     = 6,
  localparam int IDX_W   = $clog2(NUM_ENT),
  localparam int NUM_RR  = 1 << RN_W,
  localparam int OFF_W   = VA_W - RN_W,
  localparam int VPN_W   = OFF_W - PG_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrb_t           strb,
  input  logic [IDX_W-1:0]   victim,
  input  logic               rrWrEn,
  input  logic [RN_W-1:0]    rrWrIdx,
  input  logic [RID_W-1:0]   rrWrData,
  input  logic [VA_W-1:0]    lkVaddr,
  input  logic [VA_W-1:0]    insVaddr,
  input  logic [PPN_W-1:0]   insPpn,
  input  logic [VA_W-1:0]    purgeVaddr,
  input  logic [SZ_W-1:0]    purgeSize,
  output logic               lkHit,
  output logic [PPN_W-1:0]   lkPpn,
  output logic               lkHitQ,
  output logic [NUM_ENT-1:0] freeVec
);
  logic [RID_W-1:0]   rrQ   [NUM_RR];
  logic [NUM_ENT-1:0] validQ;
  logic [RID_W-1:0]   ridQ  [NUM_ENT];
  logic [VPN_W-1:0]   vpnQ  [NUM_ENT];
  logic [PPN_W-1:0]   ppnQ  [NUM_ENT];

  logic [RID_W-1:0]   lkRid, insRid, pgRid;
  logic [VPN_W-1:0]   lkVpn, insVpn, pgVpn, pgMask;
  logic [6:0]         szClamp, shAmt;
  logic [NUM_ENT-1:0] lkMatch, purgeHit;
  logic               unusedOk;

  assign unusedOk = ^{lkVaddr[PG_SHIFT-1:0], insVaddr[PG_SHIFT-1:0],
                      purgeVaddr[PG_SHIFT-1:0]};

  // region number only selects a register; it is never stored
  assign lkRid  = rrQ[lkVaddr[VA_W-1 -: RN_W]];
  assign insRid = rrQ[insVaddr[VA_W-1 -: RN_W]];
  assign pgRid  = rrQ[purgeVaddr[VA_W-1 -: RN_W]];
  assign lkVpn  = lkVaddr[OFF_W-1:PG_SHIFT];
  assign insVpn = insVaddr[OFF_W-1:PG_SHIFT];
  assign pgVpn  = purgeVaddr[OFF_W-1:PG_SHIFT];

  always_comb begin
    if (7'(purgeSize) < 7'(PG_SHIFT))   szClamp = 7'(PG_SHIFT);
    else if (7'(purgeSize) > 7'(OFF_W)) szClamp = 7'(OFF_W);
    else                                szClamp = 7'(purgeSize);
  end
  assign shAmt  = szClamp - 7'(PG_SHIFT);
  assign pgMask = {VPN_W{1'b1}} << shAmt;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign lkMatch[e]  = validQ[e] && (ridQ[e] == lkRid) && (vpnQ[e] == lkVpn);
    assign purgeHit[e] = validQ[e] && (ridQ[e] == pgRid) &&
                         (((vpnQ[e] ^ pgVpn) & pgMask) == '0);
  end

  assign lkHit   = |lkMatch;
  assign freeVec = ~validQ;

  always_comb begin
    lkPpn = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lkMatch[i]) lkPpn = ppnQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_RR; r++) rrQ[r] <= '0;
    end else if (rrWrEn) begin
      rrQ[rrWrIdx] <= rrWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      lkHitQ <= 1'b0;
    end else begin
      lkHitQ <= lkHit;
      if (strb.purgeAll)  validQ <= '0;
      else if (strb.purge) validQ <= validQ & ~purgeHit;
      else if (strb.ins)   validQ[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.ins) begin
      ridQ[victim] <= insRid;
      vpnQ[victim] <= insVpn;
      ppnQ[victim] <= insPpn;
    end
  end

  // R10
  purge_all_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.purgeAll |=> (validQ == '0));
  // R11
  no_ins_on_purge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.purge || strb.purgeAll) |=> ((validQ & ~$past(validQ)) == '0));
  // R8
  purge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.purge |=> ((validQ & $past(purgeHit)) == '0));
  // R6
  ins_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ins |=> validQ[$past(victim)]);
  // R5
  lk_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lkHitQ == $past(lkHit)));
endmodule

// File: rtl/region_tlb.sv
module region_tlb
  import rtlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int RID_W   = 24,
  parameter int PPN_W   = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rrWrEn,
  input  logic [2:0]       rrWrIdx,
  input  logic [RID_W-1:0] rrWrData,
  input  logic [63:0]      lkVaddr,
  output logic             lkHit,
  output logic [PPN_W-1:0] lkPpn,
  output logic             lkHitQ,
  input  logic             insEn,
  input  logic [63:0]      insVaddr,
  input  logic [PPN_W-1:0] insPpn,
  input  logic             purgeEn,
  input  logic [63:0]      purgeVaddr,
  input  logic [5:0]       purgeSize,
  input  logic             purgeAllEn
);
  localparam int IDX_W = $clog2(NUM_ENT);

  tlbStrb_t           strb;
  logic [IDX_W-1:0]   victim;
  logic [NUM_ENT-1:0] freeVec;

  rtlb_ctrl #(.NUM_ENT(NUM_ENT)) u_ctrl (
    .clk, .rstN, .insEn, .purgeEn, .purgeAllEn,
    .freeVec, .strb, .victim
  );

  rtlb_dp #(
    .NUM_ENT(NUM_ENT), .RID_W(RID_W), .PPN_W(PPN_W),
    .VA_W(64), .RN_W(3), .PG_SHIFT(12), .SZ_W(6)
  ) u_dp (
    .clk, .rstN, .strb, .victim,
    .rrWrEn, .rrWrIdx, .rrWrData,
    .lkVaddr, .insVaddr, .insPpn,
    .purgeVaddr, .purgeSize,
    .lkHit, .lkPpn, .lkHitQ, .freeVec
  );
endmodule

// File: tb/region_tlb_tb.sv
`timescale 1ns/1ps
module region_tlb_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rrWrEn = 1'b0;
  logic [2:0]  rrWrIdx = '0;
  logic [23:0] rrWrData = '0;
  logic [63:0] lkVaddr = '0;
  logic        lkHit, lkHitQ;
  logic [39:0] lkPpn;
  logic        insEn = 1'b0;
  logic [63:0] insVaddr = '0;
  logic [39:0] insPpn = '0;
  logic        purgeEn = 1'b0;
  logic [63:0] purgeVaddr = '0;
  logic [5:0]  purgeSize = '0;
  logic        purgeAllEn = 1'b0;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  region_tlb u_dut (
    .clk, .rstN, .rrWrEn, .rrWrIdx, .rrWrData,
    .lkVaddr, .lkHit, .lkPpn, .lkHitQ,
    .insEn, .insVaddr, .insPpn,
    .purgeEn, .purgeVaddr, .purgeSize, .purgeAllEn
  );

  function automatic logic [63:0] mkVa(input int r, input logic [48:0] vpn);
    return {r[2:0], vpn, 12'h5A5};
  endfunction

  task automatic rrWrite(input int idx, input logic [23:0] d);
    @(negedge clk);
    rrWrEn = 1'b1; rrWrIdx = idx[2:0]; rrWrData = d;
    @(negedge clk);
    rrWrEn = 1'b0;
  endtask

  task automatic ins(input logic [63:0] va, input logic [39:0] ppn);
    @(negedge clk);
    insEn = 1'b1; insVaddr = va; insPpn = ppn;
    @(negedge clk);
    insEn = 1'b0;
  endtask

  task automatic purge(input logic [63:0] va, input logic [5:0] sz);
    @(negedge clk);
    purgeEn = 1'b1; purgeVaddr = va; purgeSize = sz;
    @(negedge clk);
    purgeEn = 1'b0;
  endtask

  task automatic purgeAll();
    @(negedge clk);
    purgeAllEn = 1'b1;
    @(negedge clk);
    purgeAllEn = 1'b0;
  endtask

  task automatic chkLook(input logic [63:0] va, input logic expHit,
                         input logic [39:0] expPpn, input string tag);
    @(negedge clk);
    lkVaddr = va;
    #1;
    nChk++;
    if (lkHit !== expHit || (expHit && lkPpn !== expPpn)) begin
      nFail++;
      $display("FAIL %s va=%h hit=%b ppn=%h expected hit=%b ppn=%h",
               tag, va, lkHit, lkPpn, expHit, expPpn);
    end
  endtask

  task automatic chkQ(input logic expHit, input string tag);
    @(posedge clk);
    #1;
    nChk++;
    if (lkHitQ !== expHit) begin
      nFail++;
      $display("FAIL %s lkHitQ=%b expected %b", tag, lkHitQ, expHit);
    end
  endtask

  // R1
  task automatic testReset();
    chkLook(mkVa(0, 49'h0), 1'b0, '0, "R1 reset miss r0");
    chkLook(mkVa(7, 49'h123), 1'b0, '0, "R1 reset miss r7");
    chkQ(1'b0, "R1 reset lkHitQ");
  endtask

  // R3 R5 R6
  task automatic testBasic();
    rrWrite(1, 24'hABCDE1);
    ins(mkVa(1, 49'h10), 40'h100);
    chkLook(mkVa(1, 49'h10), 1'b1, 40'h100, "R3 hit");
    chkQ(1'b1, "R5 registered hit");
    chkLook({mkVa(1, 49'h10)} ^ 64'hFFF, 1'b1, 40'h100, "R3 offset ignored");
    chkLook(mkVa(1, 49'h11), 1'b0, '0, "R3 other page miss");
    chkQ(1'b0, "R5 registered miss");
    chkLook(mkVa(0, 49'h10), 1'b0, '0, "R6 identifier stored, rid 0 misses");
  endtask

  // R4
  task automatic testAlias();
    rrWrite(4, 24'hABCDE1);
    chkLook(mkVa(4, 49'h10), 1'b1, 40'h100, "R4 alias lookup");
    purge(mkVa(4, 49'h10), 6'd12);
    chkLook(mkVa(1, 49'h10), 1'b0, '0, "R4 alias purge");
  endtask

  // R2
  task automatic testRrTiming();
    ins(mkVa(1, 49'h20), 40'h200);
    @(negedge clk);
    rrWrEn = 1'b1; rrWrIdx = 3'd1; rrWrData = 24'h222222;
    lkVaddr = mkVa(1, 49'h20);
    #1;
    nChk++;
    if (lkHit !== 1'b1) begin
      nFail++;
      $display("FAIL R2 same-cycle old value hit=%b expected 1", lkHit);
    end
    @(negedge clk);
    rrWrEn = 1'b0;
    #1;
    nChk++;
    if (lkHit !== 1'b0) begin
      nFail++;
      $display("FAIL R2 new value visible hit=%b expected 0", lkHit);
    end
    rrWrite(1, 24'hABCDE1);
    chkLook(mkVa(1, 49'h20), 1'b1, 40'h200, "R2 restored");
  endtask

  // R8
  task automatic testPurgeRange();
    purgeAll();
    for (int k = 0; k < 8; k++) ins(mkVa(1, 49'h40 + 49'(k)), 40'h400 + 40'(k));
    rrWrite(2, 24'h333333);
    ins(mkVa(2, 49'h41), 40'h999);
    purge(mkVa(1, 49'h45), 6'd14);
    for (int k = 0; k < 8; k++)
      chkLook(mkVa(1, 49'h40 + 49'(k)), (k < 4), 40'h400 + 40'(k), "R8 16KB range");
    chkLook(mkVa(2, 49'h41), 1'b1, 40'h999, "R8 other rid kept");
    purge(mkVa(1, 49'h41), 6'd5);
    chkLook(mkVa(1, 49'h41), 1'b0, '0, "R8 small size clamps to page");
    chkLook(mkVa(1, 49'h40), 1'b1, 40'h400, "R8 neighbour kept lo");
    chkLook(mkVa(1, 49'h42), 1'b1, 40'h402, "R8 neighbour kept hi");
  endtask

  // R9
  task automatic testRegionPurge();
    ins(mkVa(1, 49'h1_0000_0000_0000), 40'h777);
    purge(mkVa(1, 49'h0), 6'd63);
    chkLook(mkVa(1, 49'h40), 1'b0, '0, "R9 whole rid low");
    chkLook(mkVa(1, 49'h43), 1'b0, '0, "R9 whole rid");
    chkLook(mkVa(1, 49'h1_0000_0000_0000), 1'b0, '0, "R9 whole rid high page");
    chkLook(mkVa(2, 49'h41), 1'b1, 40'h999, "R9 other rid kept");
  endtask

  // R10
  task automatic testPurgeAll();
    ins(mkVa(1, 49'h60), 40'h600);
    purgeAll();
    chkLook(mkVa(2, 49'h41), 1'b0, '0, "R10 cleared a");
    chkLook(mkVa(1, 49'h60), 1'b0, '0, "R10 cleared b");
  endtask

  // R11
  task automatic testConflict();
    @(negedge clk);
    insEn = 1'b1; insVaddr = mkVa(1, 49'h50); insPpn = 40'h500;
    purgeEn = 1'b1; purgeVaddr = mkVa(5, 49'h999); purgeSize = 6'd12;
    @(negedge clk);
    insEn = 1'b0; purgeEn = 1'b0;
    chkLook(mkVa(1, 49'h50), 1'b0, '0, "R11 insert dropped on purge");
    @(negedge clk);
    insEn = 1'b1; insVaddr = mkVa(1, 49'h51); insPpn = 40'h501;
    purgeAllEn = 1'b1;
    @(negedge clk);
    insEn = 1'b0; purgeAllEn = 1'b0;
    chkLook(mkVa(1, 49'h51), 1'b0, '0, "R11 insert dropped on purge-all");
  endtask

  // R6 R7
  task automatic testReplace();
    for (int k = 0; k < 16; k++) ins(mkVa(1, 49'h100 + 49'(k)), 40'(k + 1));
    chkLook(mkVa(1, 49'h10F), 1'b1, 40'd16, "R6 fill all slots");
    ins(mkVa(1, 49'h200), 40'hA00);
    chkLook(mkVa(1, 49'h100), 1'b0, '0, "R7 slot0 evicted");
    chkLook(mkVa(1, 49'h101), 1'b1, 40'd2, "R7 slot1 kept");
    chkLook(mkVa(1, 49'h200), 1'b1, 40'hA00, "R7 new entry");
    ins(mkVa(1, 49'h201), 40'hA01);
    chkLook(mkVa(1, 49'h101), 1'b0, '0, "R7 slot1 evicted");
    purge(mkVa(1, 49'h105), 6'd12);
    ins(mkVa(1, 49'h202), 40'hA02);
    for (int k = 2; k < 16; k++)
      if (k != 5) chkLook(mkVa(1, 49'h100 + 49'(k)), 1'b1, 40'(k + 1), "R6 free slot reused");
    chkLook(mkVa(1, 49'h202), 1'b1, 40'hA02, "R6 inserted into hole");
    chkLook(mkVa(1, 49'h201), 1'b1, 40'hA01, "R6 earlier kept");
    ins(mkVa(1, 49'h203), 40'hA03);
    chkLook(mkVa(1, 49'h102), 1'b0, '0, "R7 pointer at slot2");
    chkLook(mkVa(1, 49'h103), 1'b1, 40'd4, "R7 slot3 kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testAlias();
    testRrTiming();
    testPurgeRange();
    testRegionPurge();
    testPurgeAll();
    testConflict();
    testReplace();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule